// File: doc/BRIEF.md
# USB Host-Loss Break Detector

This block decides whether the USB host is still present on a device that presents itself as a serial port. It uses two pieces of evidence. The first is the regular Start-of-Frame (SOF) marker, which a live host issues once per millisecond. The second is the VBUS sense level.

Two watchdog timers count microsecond ticks since the most recent SOF:

- The short timer raises a host-lost flag after 2.048 ms.
- The long timer raises a host-timeout flag after 1 s.

A 2-bit break-level setting chooses which of the two flags counts as a serial break. A low VBUS level is a break on its own. The block latches the 11-bit frame number carried by each SOF. It packs the frame number and both flags into a 16-bit status word. It issues a single-cycle interrupt pulse when a break condition begins.

Upstream logic supplies a one-cycle SOF pulse together with its frame number, plus a free-running 1 µs tick. The window lengths are parameters, given in ticks.

Top module: `usb_host_watch`

## Requirements
- R1: On a cycle with `sof_pulse` high, `frame_idx` takes the value of `sof_frame`, visible one clock later. Between SOFs it holds.
- R2: `host_lost` rises one clock after the cycle that carries the SHORT_US-th `tick_us` since the last SOF or reset.
- R3: `host_timeout` rises one clock after the cycle that carries the LONG_US-th `tick_us` since the last SOF or reset.
- R4: An SOF clears both tick counts and both flags one clock later. An SOF and a tick in the same cycle act as an SOF alone.
- R5: The tick counts saturate. Once set, a flag stays set under further ticks until the next SOF or reset.
- R6: When `brk_lvl` is 0, the break condition follows `host_lost`. When `brk_lvl` is any non-zero value, it follows `host_timeout`.
- R7: While `vbus_sense` is low, the break condition holds regardless of the flags and of `brk_lvl`.
- R8: `brk_irq` is high for exactly one clock, one clock after a cycle in which the break condition goes from false to true. A persisting or re-selected break raises no further pulse.
- R9: `usb_status` carries `frame_idx` in bits 10:0, `host_timeout` in bit 14 and `host_lost` in bit 15. Bits 13:11 read 0.
- R10: After reset, `frame_idx`, both flags, `brk_irq` and `usb_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_pulse | input | 1 | One-cycle SOF strobe |
| sof_frame | input | 11 | Frame number that accompanies `sof_pulse` |
| vbus_sense | input | 1 | VBUS present level (high = present) |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| brk_lvl | input | 2 | Break-level select: 0 uses the short window, other values use the long window |
| frame_idx | output | 11 | Most recently received frame number |
| host_lost | output | 1 | No SOF within the short window |
| host_timeout | output | 1 | No SOF within the long window |
| brk_irq | output | 1 | Single-cycle pulse at the start of a break |
| usb_status | output | 16 | Packed status word |

## Verification
Timing relative to a stimulus cycle:

- The frame index and the cleared flags appear one clock after the SOF.
- A flag appears one clock after the tick that completes its window.
- The interrupt pulse appears one clock after the cycle in which the break condition first holds. That condition uses the flag values already registered, so a break caused by a window expiring pulses two clocks after the final tick.

The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares every output on the next falling edge, so each expected value lines up with the clock at which the design is due to change. Directed checks count interrupt pulses over whole phases, which shows that a persisting break or a change of selection raises no second pulse.

// File: rtl/host_watch_pkg.sv
package host_watch_pkg;
    localparam int unsigned FRAME_BITS = 11;
    localparam int unsigned NUM_WIN    = 2;
    localparam int unsigned WIN_SHORT  = 0;
    localparam int unsigned WIN_LONG   = 1;
    localparam int unsigned STAT_BITS  = 16;
    localparam int unsigned STAT_TOUT  = 14;
    localparam int unsigned STAT_LOST  = 15;

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef struct packed {
        frame_t frame;
    } frame_state_t;

    typedef struct packed {
        logic cond;
        logic irq;
    } brk_state_t;
endpackage

// File: rtl/host_wd_timer.sv
module host_wd_timer #(
    parameter int unsigned LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hit;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d = '0;
        end else if (tick && !tmr_q.hit) begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
            if (tmr_d.cnt == CW'(LIMIT)) begin
                tmr_d.hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = tmr_q.hit;
endmodule

// File: rtl/host_brk_edge.sv
module host_brk_edge
    import host_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_ok,
    input  logic [1:0] lvl,
    input  logic       lost,
    input  logic       tout,
    output logic       irq
);
    brk_state_t brk_d, brk_q;

    always_comb begin
        brk_d      = brk_q;
        brk_d.cond = !vbus_ok || ((lvl == 2'd0) ? lost : tout);
        brk_d.irq  = brk_d.cond && !brk_q.cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) brk_q <= '0;
        else        brk_q <= brk_d;
    end

    assign irq = brk_q.irq;
endmodule

// File: rtl/usb_host_watch.sv
module usb_host_watch
    import host_watch_pkg::*;
#(
    parameter int unsigned SHORT_US = 2048,
    parameter int unsigned LONG_US  = 1000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sof_pulse,
    input  logic [FRAME_BITS-1:0] sof_frame,
    input  logic                  vbus_sense,
    input  logic                  tick_us,
    input  logic [1:0]            brk_lvl,
    output logic [FRAME_BITS-1:0] frame_idx,
    output logic                  host_lost,
    output logic                  host_timeout,
    output logic                  brk_irq,
    output logic [STAT_BITS-1:0]  usb_status
);
    logic [NUM_WIN-1:0] win_hit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int unsigned LIM = (w == WIN_SHORT) ? SHORT_US : LONG_US;
        host_wd_timer #(.LIMIT(LIM)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (sof_pulse),
            .tick    (tick_us),
            .expired (win_hit[w])
        );
    end

    frame_state_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (sof_pulse) fr_d.frame = sof_frame;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    host_brk_edge u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .vbus_ok (vbus_sense),
        .lvl     (brk_lvl),
        .lost    (win_hit[WIN_SHORT]),
        .tout    (win_hit[WIN_LONG]),
        .irq     (brk_irq)
    );

    assign frame_idx    = fr_q.frame;
    assign host_lost    = win_hit[WIN_SHORT];
    assign host_timeout = win_hit[WIN_LONG];

    always_comb begin
        usb_status                   = '0;
        usb_status[FRAME_BITS-1:0]   = fr_q.frame;
        usb_status[STAT_TOUT]        = win_hit[WIN_LONG];
        usb_status[STAT_LOST]        = win_hit[WIN_SHORT];
    end
endmodule

// File: rtl/host_watch_chk.sv
module host_watch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sof_pulse,
    input logic [10:0] sof_frame,
    input logic        tick_us,
    input logic [10:0] frame_idx,
    input logic        host_lost,
    input logic        host_timeout,
    input logic        brk_irq
);
    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |=> !brk_irq);
    // R4
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> (!host_lost && !host_timeout));
    // R1
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> (frame_idx == $past(sof_frame)));
    // R5
    lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_lost && !sof_pulse) |=> host_lost);
    // R5
    tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_timeout && !sof_pulse) |=> host_timeout);
    // R2
    lost_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_lost && !tick_us) |=> !host_lost);
endmodule

bind usb_host_watch host_watch_chk u_watch_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_pulse    (sof_pulse),
    .sof_frame    (sof_frame),
    .tick_us      (tick_us),
    .frame_idx    (frame_idx),
    .host_lost    (host_lost),
    .host_timeout (host_timeout),
    .brk_irq      (brk_irq)
);

// File: tb/usb_host_watch_test.sv
module usb_host_watch_test;
    localparam int S_LIM = 20;
    localparam int L_LIM = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_pulse = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        vbus_sense = 1'b1;
    logic        tick_us = 1'b0;
    logic [1:0]  brk_lvl = 2'd0;
    logic [10:0] frame_idx;
    logic        host_lost, host_timeout, brk_irq;
    logic [15:0] usb_status;

    always #5 clk = ~clk;

    usb_host_watch #(.SHORT_US(S_LIM), .LONG_US(L_LIM)) uut (
        .clk(clk), .rst_n(rst_n), .sof_pulse(sof_pulse), .sof_frame(sof_frame),
        .vbus_sense(vbus_sense), .tick_us(tick_us), .brk_lvl(brk_lvl),
        .frame_idx(frame_idx), .host_lost(host_lost), .host_timeout(host_timeout),
        .brk_irq(brk_irq), .usb_status(usb_status)
    );

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int tick_ph = 0;
    bit reported = 0;
    string tag = "R10";

    // behavioural reference model
    int m_cs, m_cl, m_frame;
    bit m_lost, m_tout, m_prev, m_irq;

    always @(posedge clk) begin
        bit c;
        if (!rst_n) begin
            m_cs = 0; m_cl = 0; m_frame = 0;
            m_lost = 0; m_tout = 0; m_prev = 0; m_irq = 0;
        end else begin
            c = !vbus_sense || ((brk_lvl == 0) ? m_lost : m_tout);
            m_irq = c && !m_prev;
            m_prev = c;
            if (sof_pulse) begin
                m_cs = 0; m_cl = 0; m_lost = 0; m_tout = 0;
                m_frame = sof_frame;
            end else if (tick_us) begin
                if (!m_lost) begin m_cs++; if (m_cs == S_LIM) m_lost = 1; end
                if (!m_tout) begin m_cl++; if (m_cl == L_LIM) m_tout = 1; end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk({tag, " frame_idx (R1)"}, frame_idx, m_frame);
        chk({tag, " host_lost (R2)"}, host_lost, m_lost);
        chk({tag, " host_timeout (R3)"}, host_timeout, m_tout);
        chk({tag, " brk_irq (R8)"}, brk_irq, m_irq);
        chk({tag, " usb_status (R9)"}, usb_status,
            (int'(m_lost) << 15) | (int'(m_tout) << 14) | m_frame);
    endtask

    task automatic step(input bit s, input logic [10:0] f, input bit force_tick);
        @(negedge clk);
        compare();
        irq_seen += brk_irq;
        sof_pulse = s;
        sof_frame = f;
        tick_ph++;
        tick_us = force_tick || (tick_ph % 2 == 0);
    endtask

    task automatic run(input int n, input int per, inout int fr);
        for (int i = 0; i < n; i++) begin
            bit s = (per > 0) && (i % per == per - 1);
            step(s, 11'(fr), 1'b0);
            if (s) fr = (fr + 1) % 2048;
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int fr = 2040;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 frame_idx", frame_idx, 0);
        chk("R10 host_lost", host_lost, 0);
        chk("R10 host_timeout", host_timeout, 0);
        chk("R10 brk_irq", brk_irq, 0);
        chk("R10 usb_status", usb_status, 0);
        rst_n = 1'b1;

        tag = "R1";   // periodic SOFs, frame numbers wrap past 2047
        run(120, 15, fr);
        chk("R1 no break while SOFs arrive", irq_seen, 0);

        tag = "R2";   // SOFs stop, short window expires, lvl 0 selects it
        irq_seen = 0;
        run(60, 0, fr);
        chk("R2 host_lost set", host_lost, 1);
        chk("R8 one pulse on host loss", irq_seen, 1);

        tag = "R5";   // long window expires, flags saturate
        irq_seen = 0;
        run(130, 0, fr);
        chk("R3 host_timeout set", host_timeout, 1);
        chk("R5 lost still set", host_lost, 1);
        chk("R8 no pulse while break persists", irq_seen, 0);

        tag = "R4";   // SOF together with a tick
        step(1'b1, 11'd77, 1'b1);
        step(1'b0, 11'd0, 1'b1);
        chk("R4 lost cleared", host_lost, 0);
        chk("R4 timeout cleared", host_timeout, 0);
        chk("R4 frame loaded", frame_idx, 77);

        tag = "R6";   // lvl non-zero: only the long window breaks
        brk_lvl = 2'd2;
        irq_seen = 0;
        run(70, 0, fr);
        chk("R6 lost set but no break", irq_seen, 0);
        run(90, 0, fr);
        chk("R6 break on long window", irq_seen, 1);
        brk_lvl = 2'd0;
        irq_seen = 0;
        run(10, 0, fr);
        chk("R8 reselect while broken gives no pulse", irq_seen, 0);

        tag = "R7";   // VBUS drop with flags clear
        step(1'b1, 11'd300, 1'b0);
        run(6, 0, fr);
        irq_seen = 0;
        vbus_sense = 1'b0;
        brk_lvl = 2'd3;
        run(10, 0, fr);
        chk("R7 vbus low breaks", irq_seen, 1);
        brk_lvl = 2'd0;
        irq_seen = 0;
        run(60, 0, fr);
        vbus_sense = 1'b1;
        run(10, 0, fr);
        chk("R7 lost during vbus low gives no extra pulse", irq_seen, 0);
        run(40, 7, fr);

        report();
    end
endmodule